// File: doc/BRIEF.md
# Bit-Serial Bus-Strobe EEPROM Device Port

This block is the device side of a small nonvolatile byte store that a host reaches with nothing more than its ordinary memory-bus strobes. A single data line carries one bit per strobe. A write strobe (active-low write enable) clocks a bit in, and a read strobe (active-low output enable) presents a bit out. An active-low chip select frames each command. There is no dedicated serial clock. The strobe pins are sampled by the block's system clock, and a strobe counts once, on the first clock at which the pin is seen low after having been high.

A frame begins with an 8-bit opcode, sent MSB first. Read and write opcodes are followed by a 16-bit address, also MSB first. The block then streams array bytes out, or collects data bytes into a 32-entry page buffer. When chip select rises, a timed nonvolatile cycle copies the buffered bytes into an 8K x 8 register array. While that cycle runs, data commands are ignored. A status opcode stays available during the cycle, and write protect can veto a new cycle. The data line has no flow control: every strobe moves one bit, and the host paces the transfer with its own strobes.

Top module: `bsp_eeprom`

## Requirements
- R1: While cs_n is high, dq_oe is 0, strobes are ignored, and the frame restarts at the opcode on the next select.
- R2: dq_oe is 1 exactly while cs_n and oe_n are both low. Each accepted read strobe updates dq_out on the first clock edge at which oe_n is seen low, and dq_out holds its value otherwise.
- R3: A frame sends the opcode MSB first, with 0x03 = read, 0x02 = write and 0x05 = status. Read and write are followed by a 16-bit address, MSB first, and its top 3 bits are ignored. Any other opcode, including 0x04, starts no cycle and reads as zeros.
- R4: Write data bytes are sent MSB first. A nonvolatile cycle starts on the rise of cs_n only if at least one whole byte was received and no partial byte is pending.
- R5: Successive write bytes go to successive offsets within one 32-byte page, wrapping from offset 31 to 0. Bytes beyond 32 overwrite the earliest ones.
- R6: A nonvolatile cycle lasts WCYC clocks. The array is updated when the cycle ends, and only the buffered offsets change.
- R7: If wp_n is low when cs_n rises, no cycle starts. If wp_n falls during a running cycle, that cycle still completes.
- R8: While a cycle runs, a read frame returns zeros and a write frame stores nothing and starts nothing.
- R9: A status frame returns the byte {6'b0, wp_n, busy}, with busy in bit 0. The byte repeats every 8 read strobes and is available during a cycle.
- R10: A read frame auto-increments the address after every 8 read strobes, across the whole array, wrapping from 0x1FFF to 0x0000.
- R11: standby is 1 exactly when cs_n is high and no cycle runs. A running cycle continues while the part is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, frames a command |
| oe_n | input | 1 | Active-low output enable, read strobe |
| we_n | input | 1 | Active-low write enable, write strobe |
| wp_n | input | 1 | Active-low write protect |
| dq_in | input | 1 | Bit presented by the host on the data line |
| dq_out | output | 1 | Bit driven by the block on the data line |
| dq_oe | output | 1 | Driver enable for the data line |
| standby | output | 1 | Deselected and idle |

## Verification
The hardest state to reach is a frame that overlaps a running nonvolatile cycle. The cycle length is raised in the bench so that a status frame, a whole read frame and a whole write frame all fit inside one cycle. The bench then confirms that the overlapped write left no trace once the cycle ended. Page wrap is swept over several start offsets and an overfilled page. The expected bytes are computed from a seeded arithmetic sequence. Protect is toggled both before a frame ends and in the middle of a running cycle.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam int         FADDR_W  = 16;

  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DATA} phase_t;
endpackage

// File: rtl/bsp_frame.sv
module bsp_frame
  import bsp_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              dq_in,
  input  logic              busy,
  input  logic [7:0]        rd_byte,
  output logic [7:0]        op,
  output phase_t            phase,
  output logic              acc,
  output logic              addr_done,
  output logic              byte_vld,
  output logic [7:0]        byte_data,
  output logic              aligned,
  output logic              cs_rise,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dq_out
);
  logic              cs_q, we_q, oe_q;
  logic [3:0]        cnt;
  logic [2:0]        rbit;
  logic [FADDR_W-1:0] ash;
  logic              wr_stb, rd_stb;
  logic [7:0]        op_nx, wsh_nx;
  logic [FADDR_W-1:0] ash_nx;

  assign wr_stb  = !cs_n && !we_n && we_q;
  assign rd_stb  = !cs_n && !oe_n && oe_q;
  assign cs_rise = cs_n && !cs_q;
  assign op_nx   = {op[6:0], dq_in};
  assign ash_nx  = {ash[FADDR_W-2:0], dq_in};
  assign wsh_nx  = {byte_data[6:0], dq_in};
  assign aligned = (cnt == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_q, we_q, oe_q} <= 3'b111;
      phase     <= PH_OP;
      cnt       <= '0;
      rbit      <= '0;
      op        <= '0;
      ash       <= '0;
      acc       <= 1'b0;
      byte_data <= '0;
      rd_addr   <= '0;
      dq_out    <= 1'b0;
      addr_done <= 1'b0;
      byte_vld  <= 1'b0;
    end else begin
      cs_q      <= cs_n;
      we_q      <= we_n;
      oe_q      <= oe_n;
      addr_done <= 1'b0;
      byte_vld  <= 1'b0;
      if (cs_n) begin
        phase <= PH_OP;
        cnt   <= '0;
        rbit  <= '0;
      end else begin
        if (wr_stb) begin
          unique case (phase)
            PH_OP: begin
              op <= op_nx;
              if (cnt == 4'd7) begin
                cnt   <= '0;
                phase <= (op_nx == OP_READ || op_nx == OP_WRITE) ? PH_ADDR : PH_DATA;
              end else begin
                cnt <= cnt + 4'd1;
              end
            end
            PH_ADDR: begin
              ash <= ash_nx;
              if (cnt == 4'd15) begin
                cnt       <= '0;
                phase     <= PH_DATA;
                addr_done <= 1'b1;
                acc       <= !busy;
                rd_addr   <= ash_nx[ADDR_W-1:0];
              end else begin
                cnt <= cnt + 4'd1;
              end
            end
            default: begin
              byte_data <= wsh_nx;
              if (cnt == 4'd7) begin
                cnt      <= '0;
                byte_vld <= 1'b1;
              end else begin
                cnt <= cnt + 4'd1;
              end
            end
          endcase
        end
        if (rd_stb && phase == PH_DATA) begin
          dq_out <= rd_byte[3'd7 - rbit];
          rbit   <= rbit + 3'd1;
          if (rbit == 3'd7 && op == OP_READ)
            rd_addr <= rd_addr + 1'b1;
        end
      end
    end
  end

  a_r1_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (phase == PH_OP && cnt == 4'd0));
  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(dq_out));
  a_r3_addr_only_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR) |-> (op == OP_READ || op == OP_WRITE));
endmodule

// File: rtl/bsp_pagebuf.sv
module bsp_pagebuf #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  localparam int PAGE  = 1 << PAGE_W,
  localparam int BASE_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_byte,
  input  logic              commit,
  output logic [BASE_W-1:0] page_base,
  output logic [PAGE*8-1:0] buf_flat,
  output logic [PAGE-1:0]   valid
);
  logic [PAGE_W-1:0] ptr;
  logic [7:0]        buf_q [PAGE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      page_base <= '0;
      valid     <= '0;
    end else if (load) begin
      ptr       <= addr[PAGE_W-1:0];
      page_base <= addr[ADDR_W-1:PAGE_W];
      valid     <= '0;
    end else if (wr_en) begin
      ptr        <= ptr + 1'b1;
      valid[ptr] <= 1'b1;
    end else if (commit) begin
      valid <= '0;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) buf_q[ptr] <= wr_byte;

  for (genvar g = 0; g < PAGE; g++) begin : g_flat
    assign buf_flat[g*8 +: 8] = buf_q[g];
  end

  a_r5_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> ptr == PAGE_W'($past(ptr) + 1'b1));
endmodule

// File: rtl/bsp_nvcore.sv
module bsp_nvcore #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int WCYC   = 200,
  localparam int PAGE  = 1 << PAGE_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int BASE_W = ADDR_W - PAGE_W,
  localparam int CNT_W = $clog2(WCYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wp_n,
  input  logic [BASE_W-1:0] page_base,
  input  logic [PAGE*8-1:0] buf_flat,
  input  logic [PAGE-1:0]   valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              commit,
  output logic [7:0]        rd_data
);
  logic [CNT_W-1:0] cnt;
  logic [7:0]       mem [DEPTH];

  assign commit  = busy && (cnt == '0);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(WCYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (valid[i]) mem[{page_base, PAGE_W'(i)}] <= buf_flat[i*8 +: 8];
      end
    end
  end

  a_r6_cycle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  a_r7_protect_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> wp_n);
endmodule

// File: rtl/bsp_eeprom.sv
module bsp_eeprom
  import bsp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int WCYC   = 200,
  localparam int PAGE  = 1 << PAGE_W,
  localparam int BASE_W = ADDR_W - PAGE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic wp_n,
  input  logic dq_in,
  output logic dq_out,
  output logic dq_oe,
  output logic standby
);
  logic [7:0]        op, rd_byte, byte_data, rd_data, status;
  phase_t            phase;
  logic              acc, addr_done, byte_vld, aligned, cs_rise;
  logic              busy, commit, start, load, wr_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [BASE_W-1:0] page_base;
  logic [PAGE*8-1:0] buf_flat;
  logic [PAGE-1:0]   valid;

  assign status  = {6'b0, wp_n, busy};
  assign rd_byte = (op == OP_STAT) ? status :
                   (op == OP_READ && acc) ? rd_data : 8'h00;
  assign load    = addr_done && op == OP_WRITE && !busy;
  assign wr_en   = byte_vld && op == OP_WRITE && acc;
  assign start   = cs_rise && op == OP_WRITE && phase == PH_DATA && aligned
                   && acc && (|valid) && wp_n && !busy;
  assign dq_oe   = !cs_n && !oe_n;
  assign standby = cs_n && !busy;

  bsp_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .dq_in(dq_in), .busy(busy), .rd_byte(rd_byte), .op(op), .phase(phase),
    .acc(acc), .addr_done(addr_done), .byte_vld(byte_vld),
    .byte_data(byte_data), .aligned(aligned), .cs_rise(cs_rise),
    .rd_addr(rd_addr), .dq_out(dq_out)
  );

  bsp_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .load(load), .addr(rd_addr), .wr_en(wr_en),
    .wr_byte(byte_data), .commit(commit), .page_base(page_base),
    .buf_flat(buf_flat), .valid(valid)
  );

  bsp_nvcore #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WCYC(WCYC)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .wp_n(wp_n),
    .page_base(page_base), .buf_flat(buf_flat), .valid(valid),
    .rd_addr(rd_addr), .busy(busy), .commit(commit), .rd_data(rd_data)
  );

  a_r11_standby_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !dq_oe);
endmodule

// File: tb/tb_bsp_eeprom.sv
module tb_bsp_eeprom;
  localparam int WCYC = 600;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, oe_n, we_n, wp_n, dq_in;
  logic dq_out, dq_oe, standby;
  int checks = 0, errors = 0;

  bsp_eeprom #(.WCYC(WCYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .wp_n(wp_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .standby(standby)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic wbit(input logic b);
    @(negedge clk) we_n = 1'b0; dq_in = b;
    @(negedge clk);
    @(negedge clk) we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
  endtask

  task automatic rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) oe_n = 1'b0;
      @(negedge clk) v[i] = dq_out;
      oe_n = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [15:0] a, input bit with_addr);
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    wbyte(op);
    if (with_addr) begin
      wbyte(a[15:8]);
      wbyte(a[7:0]);
    end
  endtask

  task automatic endf(input bit wait_done, output int n);
    @(negedge clk) cs_n = 1'b1;
    n = 0;
    @(negedge clk);
    if (wait_done)
      while (!standby && n < 4 * WCYC) begin n++; @(negedge clk); end
    else
      n = standby ? 0 : 1;
  endtask

  task automatic page_write(input logic [15:0] a, input int cnt, input logic [7:0] seed, output int n);
    cmd(8'h02, a, 1'b1);
    for (int i = 0; i < cnt; i++) wbyte(pv(seed, i));
    endf(1'b1, n);
  endtask

  task automatic read1(input logic [15:0] a, output logic [7:0] v);
    int n;
    cmd(8'h03, a, 1'b1);
    rbyte(v);
    endf(1'b0, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] v, v2;
    rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; wp_n = 1'b1; dq_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(standby === 1'b1, "R11 reset standby", standby, 1);
    chk(dq_oe === 1'b0, "R1 reset dq_oe", dq_oe, 0);

    // R1 / R2: driver enable combinations
    oe_n = 1'b0; @(negedge clk);
    chk(dq_oe === 1'b0, "R1 deselected hi-z", dq_oe, 0);
    cs_n = 1'b0; @(negedge clk);
    chk(dq_oe === 1'b1, "R2 driver on", dq_oe, 1);
    oe_n = 1'b1; @(negedge clk);
    chk(dq_oe === 1'b0, "R2 driver off", dq_oe, 0);
    cs_n = 1'b1; @(negedge clk);

    // R1: strobes while deselected are ignored
    wbit(1'b1); wbit(1'b0);
    page_write(16'h0123, 1, 8'hA5, n);
    chk(n == WCYC, "R6 cycle length", n, WCYC);
    read1(16'hE123, v);
    chk(v == 8'hA5, "R3 top address bits ignored", v, 8'hA5);
    read1(16'h0123, v);
    chk(v == 8'hA5, "R4 single byte stored", v, 8'hA5);

    // R8 / R9 / R11: frames overlapping a running cycle
    cmd(8'h02, 16'h0200, 1'b1);
    wbyte(8'h3C);
    endf(1'b0, n);
    chk(n == 1, "R11 busy while deselected", n, 1);
    cmd(8'h05, 16'h0, 1'b0);
    rbyte(v); rbyte(v2);
    endf(1'b0, n);
    chk(v == 8'h03, "R9 status during cycle", v, 8'h03);
    chk(v2 == 8'h03, "R9 status repeats", v2, 8'h03);
    read1(16'h0123, v);
    chk(v == 8'h00, "R8 read during cycle is zero", v, 0);
    cmd(8'h02, 16'h0123, 1'b1);
    wbyte(8'hFF);
    endf(1'b1, n);
    read1(16'h0123, v);
    chk(v == 8'hA5, "R8 write during cycle ignored", v, 8'hA5);
    read1(16'h0200, v);
    chk(v == 8'h3C, "R6 committed at cycle end", v, 8'h3C);
    cmd(8'h05, 16'h0, 1'b0); rbyte(v); endf(1'b0, n);
    chk(v == 8'h02, "R9 status idle", v, 8'h02);

    // R5 / R10: page wrap sweep over start offsets
    for (int k = 0; k < 3; k++) begin
      int off;
      logic [15:0] base;
      logic [7:0] seed;
      off = (k == 0) ? 0 : (k == 1) ? 5 : 31;
      base = 16'(32 * (3 + k));
      seed = 8'(off * 3 + 1);
      page_write(base + 16'(off), 32, seed, n);
      chk(n == WCYC, "R4 page cycle started", n, WCYC);
      cmd(8'h03, base, 1'b1);
      for (int j = 0; j < 32; j++) begin
        rbyte(v);
        chk(v == pv(seed, (j - off) & 31), "R5 page wrap offset", v, pv(seed, (j - off) & 31));
      end
      endf(1'b0, n);
    end

    // R5: overfill overwrites earliest bytes
    page_write(16'(32 * 10), 34, 8'h40, n);
    cmd(8'h03, 16'(32 * 10), 1'b1);
    for (int j = 0; j < 32; j++) begin
      rbyte(v);
      chk(v == pv(8'h40, (j < 2) ? j + 32 : j), "R5 overfill", v, pv(8'h40, (j < 2) ? j + 32 : j));
    end
    endf(1'b0, n);

    // R4: partial byte starts nothing
    cmd(8'h02, 16'h0123, 1'b1);
    wbyte(8'h77); wbit(1'b1); wbit(1'b0); wbit(1'b1);
    endf(1'b1, n);
    chk(n == 0, "R4 partial byte no cycle", n, 0);
    read1(16'h0123, v);
    chk(v == 8'hA5, "R4 partial byte no change", v, 8'hA5);

    // R3: other opcode starts nothing and reads zero
    cmd(8'h04, 16'h0, 1'b0);
    rbyte(v);
    endf(1'b1, n);
    chk(n == 0, "R3 disable opcode no cycle", n, 0);
    chk(v == 8'h00, "R3 other opcode reads zero", v, 0);

    // R7: protect
    wp_n = 1'b0;
    page_write(16'h0123, 1, 8'h11, n);
    chk(n == 0, "R7 protected no cycle", n, 0);
    read1(16'h0123, v);
    chk(v == 8'hA5, "R7 protected no change", v, 8'hA5);
    cmd(8'h05, 16'h0, 1'b0); rbyte(v); endf(1'b0, n);
    chk(v == 8'h00, "R9 status shows protect", v, 0);
    wp_n = 1'b1;
    cmd(8'h02, 16'h0123, 1'b1);
    wbyte(8'h22);
    endf(1'b0, n);
    repeat (5) @(negedge clk);
    wp_n = 1'b0;
    n = 0;
    while (!standby && n < 4 * WCYC) begin n++; @(negedge clk); end
    read1(16'h0123, v);
    chk(v == 8'h22, "R7 running cycle completes", v, 8'h22);
    wp_n = 1'b1;

    // R10: read wraps across the end of the array
    page_write(16'h1FFF, 1, 8'hC1, n);
    page_write(16'h0000, 1, 8'hC2, n);
    cmd(8'h03, 16'h1FFF, 1'b1);
    rbyte(v); rbyte(v2);
    endf(1'b0, n);
    chk(v == 8'hC1, "R10 last byte", v, 8'hC1);
    chk(v2 == 8'hC2, "R10 wrap to zero", v2, 8'hC2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule